// File: doc/BRIEF.md
# Three-Point Hartley Transform Engine (Bit-Serial, ROM-Based)

This block computes a 3-point discrete Hartley transform of three signed samples without multipliers. A one-cycle `start` pulse captures three two's-complement inputs into three shift registers. The registers then present one bit of each sample per cycle, least significant bit first, and all three advance together. Each of the three outputs has its own four-word lookup table and its own shift-accumulate unit. The table address is the XOR of the first two input bits with the third input bit. The third bit, inverted on the sign-bit cycle, decides whether the fetched word is added to the accumulator or taken from it. Before each new term the accumulator shifts right one place. After the last bit a fixed correction term is added and the result is halved, which gives the finished coefficient in fixed point with `FRAC` fractional bits.

Kernel values (rounded to `FRAC` fractional bits): Kone = 2^FRAC, Kp = round(0.3660254·2^FRAC), Km = round(−1.3660254·2^FRAC). Each table word is the signed sum Km/Kp/Kone taken over the row, with the signs picked by the address bits. Read with one extra fractional bit, that word is half of the signed sum. The correction term is minus half the row's kernel sum.

The controller has three states. The *accept* transition takes `ST_IDLE` to `ST_SHIFT` when `start` is seen. The *last-bit* transition takes `ST_SHIFT` to `ST_FINISH` after W bits. The *retire* transition takes `ST_FINISH` back to `ST_IDLE`, writes the outputs and raises `done`.

Top module: `dht3_da_engine`

## Requirements
- R1: After reset, y0, y1 and y2 are zero and done is low.
- R2: When done is high, y0 equals (x0+x1+x2)·2^FRAC, computed exactly from the inputs captured at the accepting edge.
- R3: When done is high, y1 = Kone·x0 + Kp·x1 + Km·x2 and y2 = Kone·x0 + Km·x1 + Kp·x2 exactly, with the kernel values given above. For FRAC=8 these are 256, 94 and −350.
- R4: Full-scale inputs (−2^(W−1) and 2^(W−1)−1 in any mix) produce exact results with no wrap-around.
- R5: done is high for exactly one cycle. It rises W+1 clock edges after the edge that accepts start, so one vector occupies W+2 cycles.
- R6: A start pulse that arrives while a computation is in progress has no effect. No extra done appears, and the results come from the vector that was accepted.
- R7: y0, y1 and y2 hold their last values in every cycle in which done is low, including while a new vector is being processed.
- R8: A start given in the cycle where done is high is accepted, so back-to-back vectors keep the same W+1 edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to transform x0..x2 |
| x0 | input | W | First sample, two's complement |
| x1 | input | W | Second sample, two's complement |
| x2 | input | W | Third sample, two's complement |
| y0 | output | W+FRAC+4 | Coefficient 0, FRAC fractional bits |
| y1 | output | W+FRAC+4 | Coefficient 1, FRAC fractional bits |
| y2 | output | W+FRAC+4 | Coefficient 2, FRAC fractional bits |
| done | output | 1 | One-cycle pulse when y0..y2 are new |

## Verification
Single-impulse vectors put one kernel column on the outputs, so a wrong table word or a swapped address bit shows up directly. Mixed-sign vectors exercise the add/subtract select, and vectors whose third sample is negative exercise the inverted sense on the sign-bit cycle. All-minimum and all-maximum vectors separate a correct sign-bit weight and accumulator width from one that wraps. A start injected mid-computation and a start given in the done cycle show that busy requests are dropped while back-to-back requests are taken.

// File: rtl/dht3_pkg.sv
package dht3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } dht3_state_e;

    // kernel value for cas index 0,1,2 scaled by 2^frac, rounded to nearest
    function automatic int cas_fixed(input int idx, input int frac);
        real scale;
        scale = 2.0 ** frac;
        case (idx)
            0:       return int'(scale);
            1:       return int'(0.3660254037844386 * scale);
            default: return int'(-1.3660254037844386 * scale);
        endcase
    endfunction

    function automatic int kern(input int row, input int col, input int frac);
        return cas_fixed((row * col) % 3, frac);
    endfunction

    // folded table word: third sample's kernel plus +/- the other two
    function automatic int fold_word(input int row, input int addr, input int frac);
        int k0;
        int k1;
        k0 = kern(row, 0, frac);
        k1 = kern(row, 1, frac);
        return kern(row, 2, frac) + ((addr & 1) != 0 ? -k0 : k0)
                                  + ((addr & 2) != 0 ? -k1 : k1);
    endfunction

    // correction applied after the last bit: minus the row kernel sum
    function automatic int row_offset(input int row, input int frac);
        return -(kern(row, 0, frac) + kern(row, 1, frac) + kern(row, 2, frac));
    endfunction

endpackage

// File: rtl/dht3_piso.sv
module dht3_piso #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic         bit_out
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift_en) begin
            sreg <= {1'b0, sreg[W-1:1]};
        end
    end

    assign bit_out = sreg[0];
endmodule

// File: rtl/dht3_ctrl.sv
module dht3_ctrl
    import dht3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic shift_en,
    output logic msb,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    dht3_state_e state, state_nx;
    logic [CW-1:0] bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_FINISH);
            if (state == ST_SHIFT) bit_cnt <= bit_cnt + 1'b1;
            else                   bit_cnt <= '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        shift_en = 1'b0;
        msb      = 1'b0;
        finish   = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    load     = 1'b1;
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                msb      = (bit_cnt == LAST);
                if (bit_cnt == LAST) state_nx = ST_FINISH;
            end
            ST_FINISH: begin
                finish   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
endmodule

// File: rtl/dht3_da_row.sv
module dht3_da_row
    import dht3_pkg::*;
#(
    parameter int ROW   = 0,
    parameter int W     = 8,
    parameter int FRAC  = 8,
    parameter int ACC_W = W + FRAC + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    shift_en,
    input  logic                    msb,
    input  logic                    finish,
    input  logic                    b0,
    input  logic                    b1,
    input  logic                    b2,
    output logic signed [ACC_W-1:0] y
);
    localparam int ROM_W = FRAC + 4;
    localparam logic signed [ACC_W-1:0] OFFSET = ACC_W'(row_offset(ROW, FRAC));

    logic signed [ROM_W-1:0] rom [4];

    for (genvar a = 0; a < 4; a++) begin : g_rom
        assign rom[a] = ROM_W'(fold_word(ROW, a, FRAC));
    end

    logic [1:0]              addr;
    logic signed [ROM_W-1:0] word;
    logic signed [ACC_W-1:0] word_ext, term, acc, sum_full;
    logic                    subtract;

    assign addr     = {b1 ^ b2, b0 ^ b2};
    assign word     = rom[addr];
    assign word_ext = {{(ACC_W - ROM_W){word[ROM_W-1]}}, word};
    assign subtract = ~b2 ^ msb;
    assign term     = (subtract ? -word_ext : word_ext) <<< (W - 1);
    assign sum_full = acc + OFFSET;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            y   <= '0;
        end else begin
            if (clear)         acc <= '0;
            else if (shift_en) acc <= (acc >>> 1) + term;
            if (finish)        y <= sum_full >>> 1;
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0)); // R6
endmodule

// File: rtl/dht3_da_engine.sv
module dht3_da_engine #(
    parameter int W     = 8,
    parameter int FRAC  = 8,
    parameter int OUT_W = W + FRAC + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [W-1:0]            x0,
    input  logic [W-1:0]            x1,
    input  logic [W-1:0]            x2,
    output logic signed [OUT_W-1:0] y0,
    output logic signed [OUT_W-1:0] y1,
    output logic signed [OUT_W-1:0] y2,
    output logic                    done
);
    logic load, shift_en, msb, finish, busy;
    logic [2:0] bits;
    logic [W-1:0] xin [3];
    logic signed [OUT_W-1:0] yv [3];

    assign xin[0] = x0;
    assign xin[1] = x1;
    assign xin[2] = x2;

    dht3_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load),
        .shift_en(shift_en), .msb(msb), .finish(finish), .busy(busy), .done(done)
    );

    for (genvar i = 0; i < 3; i++) begin : g_lane
        dht3_piso #(.W(W)) u_piso (
            .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
            .din(xin[i]), .bit_out(bits[i])
        );
        dht3_da_row #(.ROW(i), .W(W), .FRAC(FRAC), .ACC_W(OUT_W)) u_row (
            .clk(clk), .rst_n(rst_n), .clear(load), .shift_en(shift_en),
            .msb(msb), .finish(finish), .b0(bits[0]), .b1(bits[1]), .b2(bits[2]),
            .y(yv[i])
        );
    end

    assign y0 = yv[0];
    assign y1 = yv[1];
    assign y2 = yv[2];

    // checking state: captured inputs and latency counter
    localparam int LW = $clog2(W + 4) + 1;
    logic [LW-1:0] lat_cnt;
    logic signed [OUT_W-1:0] cap_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            cap_sum <= '0;
        end else if (load) begin
            lat_cnt <= '0;
            cap_sum <= OUT_W'($signed(x0)) + OUT_W'($signed(x1)) + OUT_W'($signed(x2));
        end else if (lat_cnt != '1) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LW'(W + 1))); // R5
    AST_ROW0_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y0 == (cap_sum <<< FRAC))); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(y0) && $stable(y1) && $stable(y2))); // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && lat_cnt < LW'(W + 1)) |=> (lat_cnt == $past(lat_cnt) + 1'b1)); // R6
endmodule

// File: tb/dht3_da_engine_bench.sv
module dht3_da_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int FRAC  = 8;
    localparam int OUT_W = W + FRAC + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] x0 = '0, x1 = '0, x2 = '0;
    logic signed [OUT_W-1:0] y0, y1, y2;
    logic done;

    dht3_da_engine #(.W(W), .FRAC(FRAC)) u_dht3_da_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .x0(x0), .x1(x1), .x2(x2),
        .y0(y0), .y1(y1), .y2(y2), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        longint e0;
        longint e1;
        longint e2;
        string  tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int pushes = 0;
    int dones  = 0;
    longint last0 = 0, last1 = 0, last2 = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kernel for FRAC=8: Kone=256, Kp=94, Km=-350
    task automatic push_exp(input int a, input int b, input int c, input string tag);
        exp_t e;
        e.e0 = 256 * (a + b + c);
        e.e1 = 256 * a + 94 * b - 350 * c;
        e.e2 = 256 * a - 350 * b + 94 * c;
        e.tag = tag;
        sb.push_back(e);
        pushes++;
    endtask

    // monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected done", dones, pushes);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(y0 == e.e0, {"R2 y0 ", e.tag}, y0, e.e0);
                chk(y1 == e.e1, {"R3 y1 ", e.tag}, y1, e.e1);
                chk(y2 == e.e2, {"R3 y2 ", e.tag}, y2, e.e2);
                last0 = e.e0; last1 = e.e1; last2 = e.e2;
            end
        end
    end

    task automatic wait_done(input string req);
        int cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!done && cnt < 100);
        chk(cnt == W + 1, req, cnt, W + 1);
    endtask

    task automatic run_vec(input int a, input int b, input int c, input string tag);
        push_exp(a, b, c, tag);
        @(negedge clk);
        x0 = W'(a); x1 = W'(b); x2 = W'(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R5 latency");
        @(negedge clk);
        chk(done == 1'b0, "R5 done width", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(y0 == 0 && y1 == 0 && y2 == 0, "R1 outputs", y0 | y1 | y2, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_vec(0, 0, 0, "zeros");
        run_vec(1, 0, 0, "impulse0");
        run_vec(0, 1, 0, "impulse1");
        run_vec(0, 0, 1, "impulse2");
        run_vec(5, -3, 7, "mixed");
        run_vec(-9, 12, -4, "neg third");
        run_vec(-1, -1, -1, "minus one");
        // R4 full scale
        run_vec(-128, -128, -128, "R4 all min");
        run_vec(127, 127, 127, "R4 all max");
        run_vec(-128, 127, -128, "R4 min max min");
        run_vec(127, -128, 127, "R4 max min max");

        // R7: outputs hold while the next vector is processed
        push_exp(3, -2, 1, "hold");
        @(negedge clk);
        x0 = W'(3); x1 = W'(-2); x2 = W'(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(y0 == last0 && y1 == last1 && y2 == last2, "R7 hold", y1, last1);
        // R6: start while busy is dropped
        x0 = W'(-50); x1 = W'(60); x2 = W'(-70);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);
        chk(sb.size() == 0, "R6 first vector retired", sb.size(), 0);
        repeat (3 * W) @(negedge clk);
        chk(dones == pushes, "R6 no extra done", dones, pushes);

        // R8: start in the done cycle
        push_exp(10, 20, -30, "b2b first");
        @(negedge clk);
        x0 = W'(10); x1 = W'(20); x2 = W'(-30);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R5 latency");
        push_exp(-77, 33, 101, "b2b second");
        x0 = W'(-77); x1 = W'(33); x2 = W'(101);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 back-to-back latency");

        // sweep of derived patterns
        for (int i = 0; i < 20; i++) begin
            run_vec(((i * 37) % 256) - 128, ((i * 91 + 17) % 256) - 128,
                    ((i * 53 + 200) % 256) - 128, "sweep");
        end

        repeat (2 * W) @(negedge clk);
        chk(sb.size() == 0 && dones == pushes, "R6 final count", dones, pushes);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule